// File: doc/BRIEF.md
# ADC Result Register Bank

This block sits between the sequencer of an eight-channel analog-to-digital converter and the register read path of a processor. Each time the sequencer finishes a conversion it pulses a result strobe with the channel number and a 12-bit code. The block stores the code as that channel's latest result and raises the channel's completion flag. When burst mode is active and a fresh result replaces one that software never collected, the channel's lost-result flag is raised too.

Software reads a 32-bit word per channel, or a status word that gathers every flag and the combined interrupt. A channel read clears that channel's flags. A status read clears nothing. The interrupt output is high while any completion flag is set. Read data is registered and appears on the cycle after the read strobe.

Top module: `adc_result_bank`

## Requirements
- R1: After reset every completion and lost-result flag is zero, `irq` is low, `rd_data` is zero, and the status word and every channel word read as zero.
- R2: A read of byte offset 4*c, with c from 0 to 7, returns channel c's word, with its latest 12-bit result in bits 15:4 and bits 3:0 and 29:16 zero. `rd_data` takes the new word on the clock edge that samples `rd_en` and holds it until the next read.
- R3: Bit 31 of a channel word is the completion flag. A result for that channel sets it, and a read of that channel's word clears it.
- R4: Bit 30 of a channel word is the lost-result flag. It is set when `burst_en` is high and a result arrives for a channel whose completion flag is already set. It is never set while `burst_en` is low. A read of that channel's word clears it.
- R5: The status word at byte offset 0x20 holds the completion flags of channels 0 to 7 in bits 7:0, the lost-result flags of channels 0 to 7 in bits 15:8, and the interrupt flag in bit 16. Bits 31:17 are zero.
- R6: `irq` and status bit 16 are both the OR of the eight completion flags.
- R7: A status read changes no flag.
- R8: When a result arrives for a channel in the same cycle as a read of that channel, the read returns the old word. The new result is then stored with its completion flag set and its lost-result flag clear.
- R9: Byte offsets 0x24 to 0x3C read as zero, and `rd_addr[1:0]` is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| burst_en | input | 1 | Burst mode active; allows lost-result flags to be set |
| res_valid | input | 1 | One-cycle strobe: a conversion has finished |
| res_chan | input | 3 | Channel of the finished conversion |
| res_data | input | 12 | Conversion code |
| rd_en | input | 1 | One-cycle read strobe |
| rd_addr | input | 6 | Byte offset of the word to read |
| rd_data | output | 32 | Registered read data |
| irq | output | 1 | High while any completion flag is set |

## Verification
The assertions assume that `rd_en` and `res_valid` are single-cycle pulses and that `res_chan` is meaningful only while `res_valid` is high. They also assume that `burst_en` is steady around each result strobe. The bench drives every input at the falling clock edge, lowers each strobe after one cycle, and changes `burst_en` only between scenarios. Same-cycle reads and results are issued on purpose, and only in the collision scenario.

// File: rtl/adc_result_bank.sv
module adc_result_bank #(
  parameter int NUM_CH   = 8,
  parameter int RES_W    = 12,
  parameter int ADDR_W   = 6,
  parameter int DATA_W   = 32,
  parameter int RES_LSB  = 4,
  parameter int OVR_BIT  = 30,
  parameter int DONE_BIT = 31
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      burst_en,
  input  logic                      res_valid,
  input  logic [$clog2(NUM_CH)-1:0] res_chan,
  input  logic [RES_W-1:0]          res_data,
  input  logic                      rd_en,
  input  logic [ADDR_W-1:0]         rd_addr,
  output logic [DATA_W-1:0]         rd_data,
  output logic                      irq
);
  localparam int CH_W   = $clog2(NUM_CH);
  localparam int IDX_W  = ADDR_W - 2;
  localparam int IRQ_IX = 2 * NUM_CH;

  logic [RES_W-1:0]  res_q [NUM_CH];
  logic [NUM_CH-1:0] done_q, ovr_q;
  logic [NUM_CH-1:0] wr_hit, rd_hit;
  logic [IDX_W-1:0]  word_idx;
  logic [DATA_W-1:0] rd_word;
  logic [1:0]        unused_addr_lsb;

  assign word_idx        = rd_addr[ADDR_W-1:2];
  assign unused_addr_lsb = rd_addr[1:0];
  assign irq             = |done_q;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    assign wr_hit[i] = res_valid && (res_chan == CH_W'(i));
    assign rd_hit[i] = rd_en && (word_idx == IDX_W'(i));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        res_q[i]  <= '0;
        done_q[i] <= 1'b0;
        ovr_q[i]  <= 1'b0;
      end else if (wr_hit[i]) begin
        res_q[i]  <= res_data;
        done_q[i] <= 1'b1;
        ovr_q[i]  <= !rd_hit[i] && (ovr_q[i] || (burst_en && done_q[i]));
      end else if (rd_hit[i]) begin
        done_q[i] <= 1'b0;
        ovr_q[i]  <= 1'b0;
      end
    end

    AST_DONE_SET: assert property (@(posedge clk) disable iff (!rst_n)
      wr_hit[i] |=> done_q[i]);  // R3
    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_hit[i] && !wr_hit[i]) |=> (!done_q[i] && !ovr_q[i]));  // R3
    AST_OVR_BURST_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovr_q[i]) |-> $past(burst_en));  // R4
    AST_COLLIDE_NO_OVR: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_hit[i] && wr_hit[i]) |=> (done_q[i] && !ovr_q[i]));  // R8
  end

  always_comb begin
    rd_word = '0;
    if (word_idx < IDX_W'(NUM_CH)) begin
      rd_word[RES_LSB +: RES_W] = res_q[word_idx[CH_W-1:0]];
      rd_word[OVR_BIT]          = ovr_q[word_idx[CH_W-1:0]];
      rd_word[DONE_BIT]         = done_q[word_idx[CH_W-1:0]];
    end else if (word_idx == IDX_W'(NUM_CH)) begin
      rd_word[NUM_CH-1:0]        = done_q;
      rd_word[IRQ_IX-1:NUM_CH]   = ovr_q;
      rd_word[IRQ_IX]            = |done_q;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     rd_data <= '0;
    else if (rd_en) rd_data <= rd_word;
  end

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));  // R2
  AST_IRQ_ON_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> irq);  // R6
  AST_STATUS_NO_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && word_idx == IDX_W'(NUM_CH) && !res_valid) |=> ($stable(done_q) && $stable(ovr_q)));  // R7
endmodule

// File: tb/test_adc_result_bank.sv
module test_adc_result_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        burst_en = 1'b0;
  logic        res_valid = 1'b0;
  logic [2:0]  res_chan = '0;
  logic [11:0] res_data = '0;
  logic        rd_en = 1'b0;
  logic [5:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        irq;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  adc_result_bank i_adc_result_bank (
    .clk(clk), .rst_n(rst_n), .burst_en(burst_en), .res_valid(res_valid),
    .res_chan(res_chan), .res_data(res_data), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_data(rd_data), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic post(input int ch, input logic [11:0] val);
    @(negedge clk);
    res_valid = 1'b1; res_chan = 3'(ch); res_data = val;
    @(negedge clk);
    res_valid = 1'b0;
  endtask

  task automatic rd(input logic [5:0] addr, output logic [31:0] val);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = addr;
    @(negedge clk);
    rd_en = 1'b0;
    val = rd_data;
  endtask

  function automatic logic [31:0] chw(input logic d, input logic o, input logic [11:0] r);
    return {d, o, 14'd0, r, 4'd0};
  endfunction

  task automatic t_reset();
    logic [31:0] v;
    check("R1 rd_data", rd_data, 32'h0);
    check("R1 irq", {31'd0, irq}, 32'h0);
    rd(6'h20, v); check("R1 status", v, 32'h0);
    rd(6'h00, v); check("R1 ch0", v, 32'h0);
  endtask

  task automatic t_store();
    logic [31:0] v;
    burst_en = 1'b0;
    post(3, 12'hABC);
    check("R6 irq set", {31'd0, irq}, 32'h1);
    rd(6'h0C, v); check("R2 R3 ch3 word", v, chw(1, 0, 12'hABC));
    repeat (3) @(negedge clk);
    check("R2 hold", rd_data, chw(1, 0, 12'hABC));
    rd(6'h0C, v); check("R3 done cleared", v, chw(0, 0, 12'hABC));
    check("R6 irq clear", {31'd0, irq}, 32'h0);
  endtask

  task automatic t_all();
    logic [31:0] v;
    for (int c = 0; c < 8; c++) post(c, 12'(c * 'h111 + 5));
    rd(6'h20, v); check("R5 status all done", v, 32'h0001_00FF);
    for (int c = 0; c < 8; c++) begin
      rd(6'(4 * c), v); check("R2 channel word", v, chw(1, 0, 12'(c * 'h111 + 5)));
    end
    rd(6'h20, v); check("R5 status empty", v, 32'h0);
  endtask

  task automatic t_no_ovr_single();
    logic [31:0] v;
    burst_en = 1'b0;
    post(5, 12'h123); post(5, 12'h456);
    rd(6'h20, v); check("R4 no overrun outside burst", v, 32'h0001_0020);
    rd(6'h14, v); check("R4 ch5 word", v, chw(1, 0, 12'h456));
  endtask

  task automatic t_ovr_burst();
    logic [31:0] v;
    burst_en = 1'b1;
    post(2, 12'h111); post(2, 12'h222);
    rd(6'h20, v); check("R4 R5 overrun in status", v, 32'h0001_0404);
    rd(6'h20, v); check("R7 status read keeps flags", v, 32'h0001_0404);
    check("R6 irq held", {31'd0, irq}, 32'h1);
    rd(6'h08, v); check("R4 ch2 overrun word", v, chw(1, 1, 12'h222));
    rd(6'h08, v); check("R4 overrun cleared", v, chw(0, 0, 12'h222));
    rd(6'h20, v); check("R4 status cleared", v, 32'h0);
    burst_en = 1'b0;
  endtask

  task automatic t_collision();
    logic [31:0] v;
    burst_en = 1'b1;
    post(6, 12'h100);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = 6'h18;
    res_valid = 1'b1; res_chan = 3'd6; res_data = 12'h200;
    @(negedge clk);
    rd_en = 1'b0; res_valid = 1'b0;
    check("R8 collision returns old", rd_data, chw(1, 0, 12'h100));
    rd(6'h18, v); check("R8 new stored, no overrun", v, chw(1, 0, 12'h200));
    rd(6'h18, v); check("R8 cleared after read", v, chw(0, 0, 12'h200));
    burst_en = 1'b0;
  endtask

  task automatic t_addr();
    logic [31:0] v;
    post(1, 12'h3C3);
    rd(6'h24, v); check("R9 offset 0x24 zero", v, 32'h0);
    rd(6'h3C, v); check("R9 offset 0x3C zero", v, 32'h0);
    rd(6'h07, v); check("R9 low bits ignored", v, chw(1, 0, 12'h3C3));
    rd(6'h22, v); check("R9 status low bits ignored", v, 32'h0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_store();
    t_all();
    t_no_ovr_single();
    t_ovr_burst();
    t_collision();
    t_addr();
    repeat (2) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule